// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Channel

This block is a single 16-bit timer channel. It counts down on a counting clock that arrives as a one-cycle enable on the system clock. It shapes an output waveform in one of six modes: a terminal-count flag, a gate-triggered one-shot, a divide-by-N rate pulse, a near-symmetric square wave, a software-started strobe and a gate-started strobe. A control interface writes a 3-bit mode code and a count value, each with its own strobe. Byte sequencing and the host bus sit outside the block. The live count is brought out so that a latching read path elsewhere can capture it.

GATE is sampled on the system clock, and its rising edge is detected there. Depending on the mode, the gate level either enables counting or has no effect, and a rising edge either starts, retriggers or restarts the count. A count value of zero stands for the full range of 2^16. A tick is one system-clock cycle with `cnt_en` high.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out` is 1 and `count` is 0. A mode write drives `out` to 0 for code 0 and to 1 for codes 1 to 5. Codes 6 and 7 behave exactly as codes 2 and 3. A count write drives `out` to 0 in mode 0 and to 1 in every other mode.
- R2: Mode 0: the first tick after a count write loads N into `count`. Each further tick with `gate` high decrements it. `out` goes to 1 on the tick where `count` reaches 0, then holds at 1 and stops counting until the next write.
- R3: Mode 1: the first tick after a `gate` rising edge loads N and drives `out` to 0. `out` returns to 1 on the Nth tick after that. A new rising edge reloads N and keeps `out` at 0.
- R4: Mode 2 (N >= 2): after the load tick, `out` is 0 for exactly the one tick period in which `count` is 1. The next tick reloads N and sets `out` to 1, giving a period of N ticks.
- R5: Mode 3 (N >= 2): within each period of N ticks, starting at the load tick, `out` is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks.
- R6: Mode 4: the first tick after a count write loads N with `out` at 1. `out` is 0 for the single tick period after the Nth counting tick, then stays at 1 with counting stopped.
- R7: Mode 5: ticks before any `gate` rising edge change nothing. The first tick after a rising edge loads N, and the strobe follows as in R6. A rising edge before the strobe reloads N.
- R8: In modes 0, 2, 3 and 4, a tick with `gate` low leaves `count` and `out` unchanged.
- R9: In modes 2 and 3, the first tick after a `gate` rising edge restarts the period. It sets `out` to 1 and loads N (mode 2) or ceil(N/2) (mode 3).
- R10: A count value of 0 counts as 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting-clock tick, one system cycle wide |
| gate | input | 1 | Gate level; rising edges act as triggers |
| mode_wr | input | 1 | Strobe: write `mode_sel` |
| mode_sel | input | 3 | Mode code 0..7 |
| count_wr | input | 1 | Strobe: write `count_val` |
| count_val | input | W | Initial count (0 means 2^W) |
| out | output | 1 | Shaped timer output |
| count | output | W | Live counter value |

## Verification
On every cycle, the assertions check that a gate edge produces a one-cycle pulse, and that a raised mode-0 output never falls without a write. They also check that a low rate or strobe output lasts a single enabled tick, that a low gate freezes the count in the gated modes, and that alias codes decode to the periodic modes. Only the bench scenarios can show the tick counts at which each mode changes its output. The same holds for the square-wave duty split for even and odd N, for retrigger and restart timing, and for the full 65536-tick range.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } tmr_mode_e;

  // Codes with bit 1 set fold onto the two periodic modes.
  function automatic tmr_mode_e norm_mode(input logic [2:0] raw);
    if (raw[1]) return tmr_mode_e'({1'b0, raw[1:0]});
    return tmr_mode_e'(raw);
  endfunction

  // Modes whose count is started by a gate edge, not by the count write.
  function automatic logic gate_started(input tmr_mode_e m);
    return (m == M_ONESHOT) || (m == M_HW_STROBE);
  endfunction

  function automatic logic is_periodic(input tmr_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R3 R7 R9: a trigger edge is a single-cycle event
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  tmr_mode_e    mode_nx,
  input  logic [2:0]   mode_sel,
  input  logic         count_wr,
  input  logic [W-1:0] count_in,
  input  logic         tick,
  input  logic         gate_rise,
  output tmr_mode_e    mode_q,
  output logic [W-1:0] init_q,
  output logic         load_go,
  output logic         trig_go
);
  logic armed_q;
  logic load_pend_q;
  logic trig_pend_q;
  logic trig_mode;
  logic no_wr;

  assign no_wr     = !mode_wr && !count_wr;
  assign trig_mode = gate_started(mode_q) || is_periodic(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_TC_INT;
      init_q      <= '0;
      armed_q     <= 1'b0;
      load_pend_q <= 1'b0;
      trig_pend_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q      <= mode_nx;
      armed_q     <= 1'b0;
      load_pend_q <= 1'b0;
      trig_pend_q <= 1'b0;
    end else if (count_wr) begin
      init_q      <= count_in;
      armed_q     <= 1'b1;
      load_pend_q <= !gate_started(mode_q);
      trig_pend_q <= 1'b0;
    end else if (tick) begin
      load_pend_q <= 1'b0;
      trig_pend_q <= 1'b0;
    end else if (gate_rise) begin
      trig_pend_q <= 1'b1;
    end
  end

  assign load_go = tick && no_wr && load_pend_q;
  assign trig_go = tick && no_wr && armed_q && trig_mode && (trig_pend_q || gate_rise);

  // R1: alias codes 6 and 7 land on the periodic modes
  a_r1_mode_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_sel[1]) |=> (mode_q == M_RATE || mode_q == M_SQUARE));

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  tmr_mode_e    mode_nx,
  input  logic [W-1:0] init,
  input  logic         mode_wr,
  input  logic         count_wr,
  input  logic         tick,
  input  logic         gate,
  input  logic         load_go,
  input  logic         trig_go,
  output logic [W-1:0] cnt,
  output logic         out
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  // Full length of a count, zero standing for 2^W.
  function automatic logic [W:0] fn_span(input logic [W-1:0] v);
    logic [W:0] s;
    s = {1'b0, v};
    if (v == '0) s[W] = 1'b1;
    return s;
  endfunction

  function automatic logic [W-1:0] fn_high_len(input logic [W-1:0] v);
    return W'((fn_span(v) + 1'b1) >> 1);
  endfunction

  function automatic logic [W-1:0] fn_low_len(input logic [W-1:0] v);
    return W'(fn_span(v) >> 1);
  endfunction

  logic run_q;
  logic out_q;
  logic step;
  logic gated_mode;

  assign gated_mode = !gate_started(mode);
  assign step       = tick && run_q && (gate || !gated_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b1;
      run_q <= 1'b0;
    end else if (mode_wr) begin
      run_q <= 1'b0;
      out_q <= (mode_nx != M_TC_INT);
    end else if (count_wr) begin
      run_q <= 1'b0;
      out_q <= (mode != M_TC_INT);
    end else if (load_go || trig_go) begin
      run_q <= 1'b1;
      cnt   <= (mode == M_SQUARE) ? fn_high_len(init) : init;
      out_q <= (mode != M_ONESHOT) && (mode != M_TC_INT);
    end else if (step) begin
      case (mode)
        M_TC_INT, M_ONESHOT: begin
          cnt <= cnt - 1'b1;
          if (cnt == ONE) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
        M_RATE: begin
          if (cnt == ONE) begin
            cnt   <= init;
            out_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == TWO) out_q <= 1'b0;
          end
        end
        M_SQUARE: begin
          if (cnt == ONE) begin
            out_q <= ~out_q;
            cnt   <= out_q ? fn_low_len(init) : fn_high_len(init);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (!out_q) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == ONE) out_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign out = out_q;

  // R2: a raised mode-0 output only falls on a write
  a_r2_tc_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TC_INT && out && !mode_wr && !count_wr) |=> out);

  // R4: the rate-mode low pulse lasts one enabled tick
  a_r4_rate_low_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RATE && !out && tick && gate && !mode_wr && !count_wr) |=> out);

  // R6 R7: strobe is a single enabled tick wide
  a_r6_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode == M_SW_STROBE) && gate) || (mode == M_HW_STROBE)) && !out && tick
      && !mode_wr && !count_wr |=> out);

  // R8: gate low freezes the count in gated modes
  a_r8_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !gate && !load_go && !trig_go && !mode_wr && !count_wr)
      |=> $stable(cnt));

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         mode_wr,
  input  logic [2:0]   mode_sel,
  input  logic         count_wr,
  input  logic [W-1:0] count_val,
  output logic         out,
  output logic [W-1:0] count
);
  tmr_mode_e    mode_nx;
  tmr_mode_e    mode_q;
  logic [W-1:0] init_q;
  logic         gate_rise;
  logic         load_go;
  logic         trig_go;

  assign mode_nx = norm_mode(mode_sel);

  tmr_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (gate),
    .rise (gate_rise)
  );

  tmr_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_nx  (mode_nx),
    .mode_sel (mode_sel),
    .count_wr (count_wr),
    .count_in (count_val),
    .tick     (cnt_en),
    .gate_rise(gate_rise),
    .mode_q   (mode_q),
    .init_q   (init_q),
    .load_go  (load_go),
    .trig_go  (trig_go)
  );

  tmr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .mode_nx (mode_nx),
    .init    (init_q),
    .mode_wr (mode_wr),
    .count_wr(count_wr),
    .tick    (cnt_en),
    .gate    (gate),
    .load_go (load_go),
    .trig_go (trig_go),
    .cnt     (count),
    .out     (out)
  );

endmodule

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic         gate = 1'b0;
  logic         mode_wr = 1'b0;
  logic [2:0]   mode_sel = 3'd0;
  logic         count_wr = 1'b0;
  logic [W-1:0] count_val = '0;
  logic         out;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_channel #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .count_wr(count_wr),
    .count_val(count_val), .out(out), .count(count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) cnt_en = 1'b1;
    @(negedge clk) cnt_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_mode(logic [2:0] m);
    @(negedge clk) begin mode_sel = m; mode_wr = 1'b1; end
    @(negedge clk) mode_wr = 1'b0;
  endtask

  task automatic wr_count(int n);
    @(negedge clk) begin count_val = W'(n); count_wr = 1'b1; end
    @(negedge clk) count_wr = 1'b0;
  endtask

  task automatic set_gate(bit v);
    @(negedge clk) gate = v;
    @(negedge clk);
  endtask

  task automatic retrig();
    set_gate(1'b0);
    set_gate(1'b1);
  endtask

  // Square wave level expected k ticks after the load tick.
  function automatic int sq_level(int n, int k);
    return ((k % n) < ((n + 1) / 2)) ? 1 : 0;
  endfunction

  task automatic t_reset();
    chk("R1 reset out", int'(out), 1);
    chk("R1 reset count", int'(count), 0);
  endtask

  task automatic t_mode0();
    set_gate(1'b1);
    wr_mode(3'd0);
    chk("R1 mode0 write drives out low", int'(out), 0);
    wr_count(5);
    tick();
    chk("R2 load tick count", int'(count), 5);
    ticks(4);
    chk("R2 count before terminal", int'(count), 1);
    chk("R2 out low before terminal", int'(out), 0);
    tick();
    chk("R2 out high at terminal", int'(out), 1);
    ticks(3);
    chk("R2 out held high", int'(out), 1);
    chk("R2 count stopped at zero", int'(count), 0);
    wr_count(3);
    chk("R1 R2 count write drops out", int'(out), 0);
  endtask

  task automatic t_gate_hold();
    wr_mode(3'd0);
    wr_count(4);
    ticks(2);
    chk("R8 counting with gate high", int'(count), 3);
    set_gate(1'b0);
    ticks(3);
    chk("R8 count frozen with gate low", int'(count), 3);
    chk("R8 out unchanged with gate low", int'(out), 0);
    set_gate(1'b1);
    ticks(2);
    chk("R8 resumes after gate high", int'(count), 1);
    chk("R8 out still low", int'(out), 0);
    tick();
    chk("R8 R2 terminal after resume", int'(out), 1);
  endtask

  task automatic t_oneshot();
    wr_mode(3'd1);
    chk("R1 mode1 write out high", int'(out), 1);
    wr_count(3);
    tick();
    chk("R3 no trigger no start", int'(out), 1);
    retrig();
    tick();
    chk("R3 out low after trigger tick", int'(out), 0);
    chk("R3 loads count", int'(count), 3);
    ticks(2);
    chk("R3 out low mid pulse", int'(out), 0);
    tick();
    chk("R3 out high after N ticks", int'(out), 1);
    retrig();
    tick();
    tick();
    chk("R3 second pulse counting", int'(count), 2);
    retrig();
    tick();
    chk("R3 retrigger reloads", int'(count), 3);
    chk("R3 retrigger keeps low", int'(out), 0);
    ticks(2);
    chk("R3 still low after retrigger", int'(out), 0);
    tick();
    chk("R3 ends N ticks after retrigger", int'(out), 1);
  endtask

  task automatic t_rate();
    wr_mode(3'd2);
    wr_count(4);
    tick();
    chk("R4 load tick out high", int'(out), 1);
    chk("R4 load tick count", int'(count), 4);
    for (int k = 1; k <= 12; k++) begin
      tick();
      chk($sformatf("R4 rate level tick %0d", k), int'(out), ((k % 4) == 3) ? 0 : 1);
    end
    ticks(2);
    chk("R4 mid period count", int'(count), 2);
    set_gate(1'b0);
    tick();
    chk("R8 rate count frozen", int'(count), 2);
    set_gate(1'b1);
    tick();
    chk("R9 rate restart count", int'(count), 4);
    chk("R9 rate restart out", int'(out), 1);
    tick();
    chk("R9 rate counts after restart", int'(count), 3);
  endtask

  task automatic t_alias();
    wr_mode(3'd6);
    wr_count(3);
    tick();
    tick();
    chk("R1 alias6 high", int'(out), 1);
    tick();
    chk("R1 alias6 low pulse", int'(out), 0);
    tick();
    chk("R1 alias6 reload", int'(count), 3);
    chk("R1 alias6 high again", int'(out), 1);
  endtask

  task automatic t_square(int n, logic [2:0] code);
    wr_mode(code);
    wr_count(n);
    tick();
    chk($sformatf("R5 N=%0d load level", n), int'(out), 1);
    for (int k = 1; k < 3 * n; k++) begin
      tick();
      chk($sformatf("R5 N=%0d tick %0d", n, k), int'(out), sq_level(n, k));
    end
    retrig();
    tick();
    chk($sformatf("R9 N=%0d square restart out", n), int'(out), 1);
    chk($sformatf("R9 N=%0d square restart count", n), int'(count), (n + 1) / 2);
  endtask

  task automatic t_sw_strobe();
    wr_mode(3'd4);
    wr_count(3);
    chk("R1 R6 out high after writes", int'(out), 1);
    tick();
    chk("R6 load count", int'(count), 3);
    ticks(2);
    chk("R6 no strobe yet", int'(out), 1);
    tick();
    chk("R6 strobe low", int'(out), 0);
    tick();
    chk("R6 strobe ends", int'(out), 1);
    ticks(3);
    chk("R6 single strobe", int'(out), 1);
    chk("R6 count stopped", int'(count), 0);
  endtask

  task automatic t_hw_strobe();
    wr_mode(3'd5);
    wr_count(2);
    ticks(3);
    chk("R7 idle without trigger out", int'(out), 1);
    chk("R7 idle without trigger count", int'(count), 0);
    retrig();
    tick();
    chk("R7 trigger loads", int'(count), 2);
    tick();
    retrig();
    tick();
    chk("R7 retrigger reloads", int'(count), 2);
    chk("R7 no strobe on retrigger", int'(out), 1);
    tick();
    chk("R7 counting after retrigger", int'(out), 1);
    tick();
    chk("R7 strobe low", int'(out), 0);
    tick();
    chk("R7 strobe ends", int'(out), 1);
  endtask

  task automatic t_full_range();
    wr_mode(3'd0);
    wr_count(0);
    @(negedge clk) cnt_en = 1'b1;
    repeat (65535) @(negedge clk);
    cnt_en = 1'b0;
    chk("R10 count near end", int'(count), 2);
    chk("R10 out still low", int'(out), 0);
    tick();
    chk("R10 out low at one", int'(out), 0);
    tick();
    chk("R10 out high after 65536", int'(out), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_hold();
    t_oneshot();
    t_rate();
    t_alias();
    t_square(5, 3'd3);
    t_square(4, 3'd7);
    t_sw_strobe();
    t_hw_strobe();
    t_full_range();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule